// File: doc/BRIEF.md
# Variable-Width Serial Peripheral Shift Engine

This block is the bit-level core of a full-duplex SPI master. It pulls words from the read side of a transmit FIFO and shifts them out on the serial data output. At the same moment it collects the same number of bits from the serial data input and writes one word per transfer into the write side of a receive FIFO. The word length is taken from the control word each time a new word starts, and can be any value from 4 to 32 bits. Clock polarity and phase follow the four usual SPI modes. A loopback bit sends the outgoing bit stream straight back into the receiver, so the serial path can be tested without a device on the bus.

A separate divider supplies a one-cycle tick. Each tick moves the serial clock by one edge, so a word of n bits takes 2n ticks. A run bit, held outside the control word, allows new words to start. Clearing it lets the current word finish, and no further word is started after that. Chip-select decoding, the FIFO storage and the register interface are outside this block.

Top module: `spi_shift_core`

## Requirements
- R1: After reset, `busy`, `tx_pop`, `rx_push` and `rx_overflow` are low. While idle, `sclk` follows the polarity bit of `ctrl_word` one cycle later.
- R2: `ctrl_word[8:4]` holds the word length minus one. Data is sent most significant bit first. Only the low n bits of `tx_data` are sent. The received word is right-aligned in `rx_data`, with every bit above bit n-1 at zero.
- R3: A length field of 0, 1 or 2 is treated as a 4-bit word.
- R4: `ctrl_word[2]` is the clock idle level. `ctrl_word[3]` selects the phase. With phase 0, input is sampled on the first edge of each bit and output changes on the second edge. With phase 1, output changes on the first edge and input is sampled on the second edge. Each word produces exactly 2n clock edges, and `sclk` is back at its idle level when the word ends.
- R5: When `ctrl_word[1]` is 1, the receiver samples `mosi` instead of `miso`.
- R6: Every word popped from the transmit FIFO gives exactly one completion: either an `rx_push` or an `rx_overflow`.
- R7: A word is popped only when `run_en` is 1 and `tx_empty` is 0. When `run_en` is cleared in the middle of a word, that word still completes and no further word starts.
- R8: If `rx_full` is 1 when a word completes, no `rx_push` is raised. Instead, `rx_overflow` pulses for one cycle.
- R9: `busy` is 1 while a word is being shifted, and also whenever `run_en` is 1 and the transmit FIFO is not empty.
- R10: Length, polarity, phase and loopback are captured when a word starts. A change to `ctrl_word` during a word does not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Allows new words to start |
| ctrl_word | input | 8 | Bits 8:1: length-1 [8:4], phase [3], polarity [2], loopback [1] |
| sclk_tick | input | 1 | One-cycle serial clock edge strobe from the divider |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 32 | Head word of the transmit FIFO (first-word fall-through) |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| rx_data | output | 32 | Received word, right-aligned |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_overflow | output | 1 | One-cycle pulse when a received word is dropped |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in flight or transmit data pending |

## Verification
The bench drives a mode-aware serial device model in all four modes, at lengths 4, 8, 12, 16 and 32, with transmit words whose upper bits are set. An engine that aligns the word wrongly would send those upper bits. One that fails to clear its receive register would leave stale ones above the received bits. The clamp is tested with a length field of 1: a design without the clamp would run a 2-bit word, and the device model would see the wrong pattern. The bench also checks the following:
- It holds the receive FIFO full to catch a design that pushes anyway or holds the overflow pulse for more than one cycle.
- It clears the run bit in the middle of a word to catch a design that cuts the word short or starts the next one.
- It changes the control word in the middle of a word to catch a design that reads its settings live rather than capturing them.

// File: rtl/spi_eng_pkg.sv
// Package: shared constants, control-word field positions and the per-word
// configuration record for the SPI shift engine.
package spi_eng_pkg;

    localparam int MAX_BITS = 32;                      // widest word
    localparam int MIN_BITS = 4;                       // narrowest word
    localparam int LEN_W    = $clog2(MAX_BITS);        // length-minus-one field
    localparam int NB_W     = $clog2(MAX_BITS + 1);    // holds a bit count
    localparam int EDGE_W   = $clog2(2 * MAX_BITS);    // serial edge index
    localparam int TWO_W    = NB_W + 1;                // holds 2 * bit count

    localparam int LOOP_POS = 1;
    localparam int CPOL_POS = 2;
    localparam int CPHA_POS = 3;
    localparam int LEN_POS  = 4;
    localparam int CTRL_HI  = LEN_POS + LEN_W - 1;     // top control bit

    typedef struct packed {
        logic            loop;
        logic            cpol;
        logic            cpha;
        logic [NB_W-1:0] nbits;
    } word_cfg_t;

    // Turns the control word into a word configuration, clamping short lengths.
    function automatic word_cfg_t decode_ctrl(input logic [CTRL_HI:LOOP_POS] c);
        word_cfg_t        r;
        logic [LEN_W-1:0] f;
        f      = c[LEN_POS +: LEN_W];
        r.loop = c[LOOP_POS];
        r.cpol = c[CPOL_POS];
        r.cpha = c[CPHA_POS];
        if (f < LEN_W'(MIN_BITS - 1))
            r.nbits = NB_W'(MIN_BITS);
        else
            r.nbits = NB_W'(f) + NB_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/spi_edge_seq.sv
// Serial clock sequencer. It counts the edges of one word and toggles sclk once per tick.
// It marks each edge as a launch edge or a sample edge, according to the phase of the word.
// Assumes: start is raised only while inactive, and last_edge = 2n-1 stays stable for the word.
module spi_edge_seq #(
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic          idle_cpol,
    input  logic          word_cpol,
    input  logic          word_cpha,
    input  logic [EW-1:0] last_edge,
    output logic          sclk,
    output logic          active,
    output logic          launch,
    output logic          sample,
    output logic          done
);
    logic          active_q;
    logic          sclk_q;
    logic [EW-1:0] edge_q;
    logic          fire;
    logic          leading;
    logic          at_last;

    // Classify the edge that the current tick produces.
    always_comb begin
        fire    = active_q && tick;
        leading = ~edge_q[0];
        at_last = (edge_q == last_edge);
        sample  = fire && (leading ^ word_cpha);
        launch  = fire && !(leading ^ word_cpha) && !at_last;
        done    = fire && at_last;
    end

    // Keep the edge count, the clock level and the word-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            edge_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            edge_q   <= '0;
            sclk_q   <= idle_cpol;
        end else if (fire) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EW'(1);
            if (at_last) active_q <= 1'b0;
        end else if (!active_q) begin
            sclk_q <= idle_cpol;
        end
    end

    assign sclk   = sclk_q;
    assign active = active_q;

    // R4
    idle_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sclk == $past(word_cpol)));
    // R4
    edge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (edge_q <= last_edge));
endmodule

// File: rtl/spi_tx_shifter.sv
// Transmit shifter. It sends an MSB-aligned word one bit per launch strobe.
// With phase 0, the first bit is put on the line as soon as the word loads.
// Assumes: load and shift are never raised in the same cycle.
module spi_tx_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         preload,
    input  logic         shift,
    output logic         mosi
);
    logic [W-1:0] sr_q;
    logic         mosi_q;

    // Load the word, or move the next bit onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            if (preload) begin
                mosi_q <= load_word[W-1];
                sr_q   <= load_word << 1;
            end else begin
                mosi_q <= 1'b0;
                sr_q   <= load_word;
            end
        end else if (shift) begin
            mosi_q <= sr_q[W-1];
            sr_q   <= sr_q << 1;
        end
    end

    assign mosi = mosi_q;
endmodule

// File: rtl/spi_rx_shifter.sv
// Receive shifter. It is cleared at the start of each word and shifts in one bit per sample strobe.
// After n samples the word is right-aligned, with zeros above it.
// Assumes: clear and sample are never raised in the same cycle.
module spi_rx_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;

    // Clear at the start of a word, then shift in from the LSB side.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr_q <= '0;
        else if (clear)  sr_q <= '0;
        else if (sample) sr_q <= {sr_q[W-2:0], din};
    end

    assign word = sr_q;
endmodule

// File: rtl/spi_shift_core.sv
// Top level of the SPI shift engine. It starts a word when running and data is waiting.
// It captures the word settings, runs the edge sequencer and both shifters, and reports
// each completion to the receive FIFO as a push or as an overflow.
// Assumes: the transmit FIFO is first-word fall-through, and sclk_tick is a one-cycle strobe.
module spi_shift_core
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_en,
    input  logic [CTRL_HI:LOOP_POS] ctrl_word,
    input  logic                    sclk_tick,
    input  logic                    tx_empty,
    input  logic [DATA_W-1:0]       tx_data,
    output logic                    tx_pop,
    input  logic                    rx_full,
    output logic [DATA_W-1:0]       rx_data,
    output logic                    rx_push,
    output logic                    rx_overflow,
    output logic                    sclk,
    output logic                    mosi,
    input  logic                    miso,
    output logic                    busy
);
    word_cfg_t         live_cfg;
    word_cfg_t         cfg_q;
    logic              active;
    logic              start;
    logic              launch;
    logic              sample;
    logic              done;
    logic              rx_in;
    logic [NB_W-1:0]   shamt;
    logic [DATA_W-1:0] aligned;
    logic [TWO_W-1:0]  two_n;
    logic [EDGE_W-1:0] last_edge;
    logic              push_q;
    logic              ovf_q;

    // Decode the control word, and decide whether a new word starts this cycle.
    always_comb begin
        live_cfg  = decode_ctrl(ctrl_word);
        start     = !active && run_en && !tx_empty;
        shamt     = NB_W'(DATA_W) - live_cfg.nbits;
        aligned   = tx_data << shamt;
        two_n     = {cfg_q.nbits, 1'b0};
        last_edge = EDGE_W'(two_n - TWO_W'(1));
        rx_in     = cfg_q.loop ? mosi : miso;
    end

    // Capture the word settings at the start of each word.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (start) cfg_q <= live_cfg;
    end

    // Turn word completion into a push, or into an overflow when the FIFO is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            push_q <= done && !rx_full;
            ovf_q  <= done && rx_full;
        end
    end

    spi_edge_seq #(.EW(EDGE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(sclk_tick),
        .idle_cpol(live_cfg.cpol), .word_cpol(cfg_q.cpol), .word_cpha(cfg_q.cpha),
        .last_edge(last_edge), .sclk(sclk), .active(active),
        .launch(launch), .sample(sample), .done(done)
    );

    spi_tx_shifter #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(start), .load_word(aligned),
        .preload(!live_cfg.cpha), .shift(launch), .mosi(mosi)
    );

    spi_rx_shifter #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample),
        .din(rx_in), .word(rx_data)
    );

    assign tx_pop      = start;
    assign rx_push     = push_q;
    assign rx_overflow = ovf_q;
    assign busy        = active || (run_en && !tx_empty);

    // Words popped but not yet completed (assertion bookkeeping only).
    logic [1:0] inflight_q;
    always_ff @(posedge clk) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + {1'b0, tx_pop} - {1'b0, (push_q || ovf_q)};
    end

    // R6
    inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 2'd1);
    // R6
    pop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (inflight_q == 2'd0 || push_q || ovf_q));
    // R8
    ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> !rx_push);
    // R8
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> $past(rx_full));
    // R9
    busy_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> busy);
endmodule

// File: tb/test_spi_shift_core.sv
module test_spi_shift_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [8:1]  ctrl_word = '0;
    logic        sclk_tick = 1'b0;
    logic        tx_empty;
    logic [31:0] tx_data;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic [31:0] rx_data;
    logic        rx_push;
    logic        rx_overflow;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    spi_shift_core i_spi_shift_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ctrl_word(ctrl_word),
        .sclk_tick(sclk_tick), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push), .rx_overflow(rx_overflow),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
    );

    // Tick every third cycle
    int tdiv = 0;
    always @(posedge clk) begin
        tdiv      <= (tdiv == 2) ? 0 : tdiv + 1;
        sclk_tick <= (tdiv == 2);
    end

    // Transmit FIFO model
    logic [31:0] txq [16];
    logic [3:0]  wr_p = '0;
    logic [3:0]  rd_p = '0;
    int pops = 0;
    assign tx_empty = (wr_p == rd_p);
    assign tx_data  = txq[rd_p];
    always @(posedge clk) if (tx_pop) begin rd_p <= rd_p + 4'd1; pops <= pops + 1; end

    // Receive FIFO model
    logic [31:0] last_rx = '0;
    int pushes = 0;
    int ovfs   = 0;
    always @(posedge clk) begin
        if (rx_push) begin last_rx <= rx_data; pushes <= pushes + 1; end
        if (rx_overflow) ovfs <= ovfs + 1;
    end

    // Serial device model
    int          s_len = 8;
    logic        s_cpol = 0, s_cpha = 0;
    logic [31:0] s_word = '0;
    logic [31:0] s_rx = '0;
    logic        prev_sclk = 0;
    int          idx = 0;
    always @(negedge clk) begin
        if (tx_pop) begin
            s_rx = '0;
            if (!s_cpha) begin miso = s_word[s_len-1]; idx = s_len - 2; end
            else idx = s_len - 1;
        end else if (sclk != prev_sclk) begin
            if ((prev_sclk == s_cpol) ^ s_cpha) s_rx = {s_rx[30:0], mosi};
            else begin
                if (idx >= 0) miso = s_word[idx];
                idx = idx - 1;
            end
        end
        prev_sclk = sclk;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_tx(input logic [31:0] w);
        txq[wr_p] = w;
        wr_p = wr_p + 4'd1;
    endtask

    function automatic logic [7:0] mk_ctrl(input int field, input bit cpol, input bit cpha, input bit loop);
        logic [8:0] c;
        c = {field[4:0], cpha, cpol, loop, 1'b0};
        return c[8:1];
    endfunction

    task automatic wait_done(input int target);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (pushes + ovfs >= target) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // One word in a given mode; checks both serial directions and the idle level.
    task automatic run_word(input int field, input bit cpol, input bit cpha, input bit loop,
                            input logic [31:0] txw, input logic [31:0] slw, input string tag);
        int n; logic [31:0] m; int tgt;
        n = (field < 3) ? 4 : field + 1;
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        @(negedge clk);
        s_len = n; s_cpol = cpol; s_cpha = cpha; s_word = slw;
        ctrl_word = mk_ctrl(field, cpol, cpha, loop);
        repeat (2) @(negedge clk);
        tgt = pushes + ovfs + 1;
        run_en = 1'b1;
        push_tx(txw);
        wait_done(tgt);
        check(s_rx == (txw & m), {tag, " device got MSB-first low bits"}, s_rx, txw & m);
        check(last_rx == (loop ? (txw & m) : (slw & m)), {tag, " rx right-aligned"},
              last_rx, loop ? (txw & m) : (slw & m));
        check(sclk == cpol, {"R4 idle level after word ", tag}, {31'd0, sclk}, {31'd0, cpol});
    endtask

    task automatic t_reset();
        check(busy == 0 && tx_pop == 0 && rx_push == 0 && rx_overflow == 0, "R1 reset outputs",
              {28'd0, busy, tx_pop, rx_push, rx_overflow}, 32'd0);
        check(sclk == 0, "R1 sclk idle low", {31'd0, sclk}, 32'd0);
        ctrl_word = mk_ctrl(7, 1, 0, 0);
        repeat (2) @(negedge clk);
        check(sclk == 1, "R1 sclk follows polarity when idle", {31'd0, sclk}, 32'd1);
        ctrl_word = mk_ctrl(7, 0, 0, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_modes();
        run_word(7,  0, 0, 0, 32'hFFFF_FFA5, 32'hFFFF_FF3C, "R2 R4 mode0 8b");
        run_word(11, 1, 1, 0, 32'h0000_0ABC, 32'h0000_05A3, "R2 R4 mode3 12b");
        run_word(31, 0, 1, 0, 32'hDEAD_BEEF, 32'h1234_5678, "R2 R4 mode1 32b");
        run_word(15, 1, 0, 0, 32'h1234_8001, 32'hFFFF_7FFE, "R2 R4 mode2 16b");
    endtask

    task automatic t_loop();
        run_word(3,  0, 0, 1, 32'h0000_0009, 32'h0000_0006, "R5 loop 4b");
        run_word(31, 1, 1, 1, 32'hC0FF_EE11, 32'h0F00_11EE, "R5 loop 32b");
    endtask

    task automatic t_clamp();
        run_word(1, 0, 0, 0, 32'h0000_00FA, 32'h0000_0005, "R3 clamp 4b");
    endtask

    task automatic t_count();
        int p0, q0;
        p0 = pops; q0 = pushes;
        ctrl_word = mk_ctrl(7, 0, 0, 0); s_len = 8; s_cpol = 0; s_cpha = 0;
        push_tx(32'h11); push_tx(32'h22); push_tx(32'h33);
        wait_done(pushes + ovfs + 3);
        check(pops - p0 == 3, "R6 three pops", pops - p0, 3);
        check(pushes - q0 == 3, "R6 three pushes", pushes - q0, 3);
        check(busy == 0, "R9 busy low when drained", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_overflow();
        int q0, o0, wide;
        q0 = pushes; o0 = ovfs; wide = 0;
        rx_full = 1'b1;
        push_tx(32'h5A);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rx_overflow) wide = wide + 1;
            if (ovfs > o0 && !rx_overflow && !busy) break;
        end
        check(pushes == q0, "R8 no push when full", pushes, q0);
        check(ovfs - o0 == 1, "R8 one overflow", ovfs - o0, 1);
        check(wide == 1, "R8 overflow pulse one cycle", wide, 1);
        rx_full = 1'b0;
    endtask

    task automatic t_disabled();
        int p0;
        p0 = pops;
        run_en = 1'b0;
        push_tx(32'h77);
        repeat (60) @(negedge clk);
        check(pops == p0, "R7 no pop while disabled", pops, p0);
        check(busy == 0, "R9 busy low while disabled", {31'd0, busy}, 32'd0);
        run_en = 1'b1;
        @(negedge clk);
        check(busy == 1, "R9 busy with pending data", {31'd0, busy}, 32'd1);
        wait_done(pushes + ovfs + 1);
        check(pops == p0 + 1, "R7 pop after enable", pops, p0 + 1);
    endtask

    task automatic t_stop_mid();
        int p0, q0;
        p0 = pops; q0 = pushes;
        push_tx(32'hC3); push_tx(32'h3C);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pops > p0) break;
        end
        repeat (10) @(negedge clk);
        check(busy == 1, "R9 busy mid word", {31'd0, busy}, 32'd1);
        run_en = 1'b0;
        repeat (120) @(negedge clk);
        check(pushes == q0 + 1, "R7 word finishes after stop", pushes, q0 + 1);
        check(pops == p0 + 1, "R7 no new word after stop", pops, p0 + 1);
        check(sclk == 0, "R7 clock idle after stop", {31'd0, sclk}, 32'd0);
        run_en = 1'b1;
        wait_done(q0 + 2 + ovfs);
    endtask

    task automatic t_latch();
        int tgt;
        ctrl_word = mk_ctrl(7, 0, 0, 0); s_len = 8; s_cpol = 0; s_cpha = 0;
        s_word = 32'h96;
        repeat (2) @(negedge clk);
        tgt = pushes + ovfs + 1;
        push_tx(32'h4B);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (busy) break;
        end
        repeat (4) @(negedge clk);
        ctrl_word = mk_ctrl(3, 0, 0, 1);
        wait_done(tgt);
        check(last_rx == 32'h96, "R10 settings held during word", last_rx, 32'h96);
        check(s_rx == 32'h4B, "R10 length held during word", s_rx, 32'h4B);
        ctrl_word = mk_ctrl(7, 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_loop();
        t_clamp();
        t_count();
        t_overflow();
        t_disabled();
        t_stop_mid();
        t_latch();
        summary();
        $finish;
    end
endmodule